// File: doc/BRIEF.md
# Floating-Point Status and Exception-Control Register

This block is the 32-bit status and control register that sits next to a floating-point datapath. Software reads the whole register on a read port and updates it on a write port. The datapath reports each executed operation with a one-cycle strobe. With the strobe it gives a vector of the exception conditions that operation raised, and a flag that says the operation saw a denormal operand. The register keeps the rounding-mode selection, a denormal-flush control, one trap enable per maskable exception class, a cause bit per class and a sticky flag per maskable class. It drives the rounding mode and the flush control to the datapath. When an operation raises an exception that is not masked, it sends a one-cycle trap request to the processor's exception logic.

Bits are numbered here with bit 0 as the least significant bit. The exception classes use one index order across the input vector, the cause field, the enable field and the flag field: 0 invalid, 1 overflow, 2 divide-by-zero, 3 underflow, 4 inexact, 5 unimplemented. The unimplemented class has a cause bit but no enable bit and no sticky flag. It always requests a trap.

Top module: `fpsr_csr`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x0000_0000, `round_mode` is 0 (round to nearest), `flush_denorm` is 0 and `trap_req` is 0.
- R2: A software write loads the control fields directly. The rounding mode is in bits [1:0], coded 0 = nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity, and appears on `round_mode`. The flush control is in bit 8 and appears on `flush_denorm`. The enables are in bits [14:10], class k at bit 10+k. Control fields keep their value when there is no write.
- R3: Bits 9, 15 and 31:21 always read 0. Writing 1 to them changes nothing.
- R4: Cause bits [7:2] (class k at bit 2+k) and sticky flags [20:16] (class k at bit 16+k) can only be cleared by software. Writing 0 clears the bit, and writing 1 leaves it as it was.
- R5: An operation strobe replaces every cause bit with the conditions raised by that operation, on the clock edge that ends the strobe cycle. When there is no strobe the cause bits keep their value.
- R6: A denormal operand raises the unimplemented class (cause bit 7) when the flush control is 0. When the flush control is 1 it raises nothing.
- R7: `trap_req` is high for exactly the cycle after a strobe whose raised conditions include an enabled class or the unimplemented class. It is low otherwise.
- R8: When an operation raises only masked conditions and does not trap, those maskable classes set their sticky flags. An operation never clears a sticky flag.
- R9: When an operation traps, including the case of one enabled and one masked condition raised together, no sticky flag changes.
- R10: When a software write and a strobe fall in the same cycle, the cause bits take the operation's conditions. The trap decision uses the enables held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_wr_en | input | 1 | Software write strobe |
| csr_wr_data | input | 32 | Software write value |
| csr_rd_data | output | 32 | Current register contents |
| op_valid | input | 1 | An FPU operation executed this cycle |
| op_exc | input | 6 | Conditions raised by the operation, one bit per class |
| op_denorm | input | 1 | The operation had a denormal operand |
| round_mode | output | 2 | Rounding mode to the datapath |
| flush_denorm | output | 1 | Treat denormal operands as zero |
| trap_req | output | 1 | One-cycle trap request to the exception logic |

## Verification
A single masked condition, a single enabled condition, and a mixed pair with one enabled and one masked condition are applied in turn. This shows whether the flags, the trap and the cause update are tied to the right enable bits. A denormal operand is applied once with flush off and once with flush on, which shows whether the unimplemented path honours the flush control. All-ones writes over set cause and flag bits, and a write in the same cycle as an operation, test the clear-only rule and the write/update priority. All-ones and single-reserved-bit writes test the reserved positions.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   localparam int unsigned CLASS_INVALID  = 0;
   localparam int unsigned CLASS_OVERFLOW = 1;
   localparam int unsigned CLASS_DIVZERO  = 2;
   localparam int unsigned CLASS_UNDERFL  = 3;
   localparam int unsigned CLASS_INEXACT  = 4;

   localparam int unsigned RM_W = 2;

   typedef enum logic [RM_W-1:0] {
      RND_NEAREST  = 2'b00,
      RND_ZERO     = 2'b01,
      RND_POS_INF  = 2'b10,
      RND_NEG_INF  = 2'b11
   } rnd_mode_e;
endpackage

// File: rtl/fpsr_ctrl_regs.sv
module fpsr_ctrl_regs
   import fpsr_pkg::*;
#(
   parameter int unsigned N_MASK = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RM_W-1:0]   wr_rm,
   input  logic              wr_flush,
   input  logic [N_MASK-1:0] wr_enable,
   output rnd_mode_e         rm_q,
   output logic              flush_q,
   output logic [N_MASK-1:0] enable_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rm_q     <= RND_NEAREST;
         flush_q  <= 1'b0;
         enable_q <= '0;
      end else if (wr_en) begin
         rm_q     <= rnd_mode_e'(wr_rm);
         flush_q  <= wr_flush;
         enable_q <= wr_enable;
      end
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(rm_q) && $stable(flush_q) && $stable(enable_q))); // R2
endmodule

// File: rtl/fpsr_trap_gen.sv
module fpsr_trap_gen #(
   parameter int unsigned N_MASK       = 5,
   parameter bit          UNIMPL_TRAPS = 1'b1,
   localparam int unsigned N_CLASS     = N_MASK + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [N_CLASS-1:0] op_exc,
   input  logic               op_denorm,
   input  logic               flush,
   input  logic [N_MASK-1:0]  enable,
   output logic [N_CLASS-1:0] raised,
   output logic               trap_hit,
   output logic               trap_q
);
   logic [N_CLASS-1:0] enable_eff;
   logic               denorm_unimpl;

   generate
      if (UNIMPL_TRAPS) begin : g_unimpl_traps
         assign enable_eff = {1'b1, enable};
      end else begin : g_unimpl_masked
         assign enable_eff = {1'b0, enable};
      end
   endgenerate

   always_comb begin
      denorm_unimpl = op_denorm && !flush;
      raised        = op_exc;
      raised[N_CLASS-1] = op_exc[N_CLASS-1] | denorm_unimpl;
      trap_hit      = op_valid && (|(raised & enable_eff));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) trap_q <= 1'b0;
      else        trap_q <= trap_hit;
   end

   AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> $past(op_valid)); // R7
   AST_NO_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !trap_q); // R7
endmodule

// File: rtl/fpsr_exc_slice.sv
module fpsr_exc_slice #(
   parameter bit HAS_FLAG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  logic raised,
   input  logic trap_hit,
   input  logic wr_en,
   input  logic wr_cause_bit,
   input  logic wr_flag_bit,
   output logic cause_q,
   output logic flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)        cause_q <= 1'b0;
      else if (op_valid) cause_q <= raised;
      else if (wr_en)    cause_q <= cause_q & wr_cause_bit;
   end

   generate
      if (HAS_FLAG) begin : g_sticky
         logic kept;
         logic set_now;
         always_comb begin
            kept    = wr_en ? (flag_q & wr_flag_bit) : flag_q;
            set_now = op_valid && raised && !trap_hit;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= kept | set_now;
         end

         AST_FLAG_KEEP_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && trap_hit) |=> !$rose(flag_q)); // R9
         AST_FLAG_NOT_CLEARED_BY_OP: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !wr_en) |=> flag_q); // R8
      end else begin : g_no_sticky
         logic unused_flag_in;
         assign unused_flag_in = wr_flag_bit;
         assign flag_q = 1'b0;
      end
   endgenerate

   AST_CAUSE_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (cause_q == $past(raised))); // R5
   AST_CAUSE_WRITE_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !$rose(cause_q)); // R4
endmodule

// File: rtl/fpsr_csr.sv
module fpsr_csr
   import fpsr_pkg::*;
#(
   parameter int unsigned REG_W        = 32,
   parameter int unsigned N_MASK       = 5,
   parameter int unsigned FLUSH_BIT    = 8,
   parameter int unsigned CAUSE_LSB    = 2,
   parameter int unsigned EN_LSB       = 10,
   parameter int unsigned FLAG_LSB     = 16,
   parameter bit          UNIMPL_TRAPS = 1'b1,
   localparam int unsigned N_CLASS     = N_MASK + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_wr_en,
   input  logic [REG_W-1:0]   csr_wr_data,
   output logic [REG_W-1:0]   csr_rd_data,
   input  logic               op_valid,
   input  logic [N_CLASS-1:0] op_exc,
   input  logic               op_denorm,
   output logic [RM_W-1:0]    round_mode,
   output logic               flush_denorm,
   output logic               trap_req
);
   initial begin
      assert (CAUSE_LSB >= RM_W && CAUSE_LSB + N_CLASS <= FLUSH_BIT)
         else $error("cause field collides with rounding or flush bits");
      assert (EN_LSB > FLUSH_BIT && EN_LSB + N_MASK <= FLAG_LSB)
         else $error("enable field misplaced");
      assert (FLAG_LSB + N_MASK <= REG_W)
         else $error("flag field exceeds register width");
      assert (N_MASK >= 1 && N_MASK <= 5)
         else $error("N_MASK out of range");
   end

   rnd_mode_e          rm_q;
   logic               flush_q;
   logic [N_MASK-1:0]  enable_q;
   logic [N_CLASS-1:0] raised;
   logic               trap_hit;
   logic [N_CLASS-1:0] cause_vec;
   logic [N_CLASS-1:0] flag_vec;
   logic               unused_top;

   fpsr_ctrl_regs #(.N_MASK(N_MASK)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (csr_wr_en),
      .wr_rm     (csr_wr_data[RM_W-1:0]),
      .wr_flush  (csr_wr_data[FLUSH_BIT]),
      .wr_enable (csr_wr_data[EN_LSB +: N_MASK]),
      .rm_q      (rm_q),
      .flush_q   (flush_q),
      .enable_q  (enable_q)
   );

   fpsr_trap_gen #(.N_MASK(N_MASK), .UNIMPL_TRAPS(UNIMPL_TRAPS)) u_trap (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_exc    (op_exc),
      .op_denorm (op_denorm),
      .flush     (flush_q),
      .enable    (enable_q),
      .raised    (raised),
      .trap_hit  (trap_hit),
      .trap_q    (trap_req)
   );

   generate
      for (genvar k = 0; k < N_CLASS; k++) begin : g_class
         localparam bit STICKY = (k < N_MASK);
         logic flag_wbit;
         if (STICKY) begin : g_wf
            assign flag_wbit = csr_wr_data[FLAG_LSB + k];
         end else begin : g_nf
            assign flag_wbit = 1'b1;
         end
         fpsr_exc_slice #(.HAS_FLAG(STICKY)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .op_valid     (op_valid),
            .raised       (raised[k]),
            .trap_hit     (trap_hit),
            .wr_en        (csr_wr_en),
            .wr_cause_bit (csr_wr_data[CAUSE_LSB + k]),
            .wr_flag_bit  (flag_wbit),
            .cause_q      (cause_vec[k]),
            .flag_q       (flag_vec[k])
         );
      end
   endgenerate

   assign unused_top = flag_vec[N_CLASS-1];

   always_comb begin
      csr_rd_data                        = '0;
      csr_rd_data[RM_W-1:0]              = rm_q;
      csr_rd_data[FLUSH_BIT]             = flush_q;
      csr_rd_data[CAUSE_LSB +: N_CLASS]  = cause_vec;
      csr_rd_data[EN_LSB +: N_MASK]      = enable_q;
      csr_rd_data[FLAG_LSB +: N_MASK]    = flag_vec[N_MASK-1:0];
   end

   assign round_mode   = rm_q;
   assign flush_denorm = flush_q;

   AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (|cause_vec)); // R7
   AST_OP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && csr_wr_en) |=> (cause_vec == $past(raised))); // R10
   AST_RESET_CLEAN: assert property (@(posedge clk)
      !rst_n |=> (csr_rd_data == '0 && !trap_req)); // R1
endmodule

// File: tb/fpsr_csr_bench.sv
module fpsr_csr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr_en = 1'b0;
   logic [31:0] csr_wr_data = '0;
   logic [31:0] csr_rd_data;
   logic        op_valid = 1'b0;
   logic [5:0]  op_exc = '0;
   logic        op_denorm = 1'b0;
   logic [1:0]  round_mode;
   logic        flush_denorm;
   logic        trap_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fpsr_csr u_fpsr_csr (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_wr_en    (csr_wr_en),
      .csr_wr_data  (csr_wr_data),
      .csr_rd_data  (csr_rd_data),
      .op_valid     (op_valid),
      .op_exc       (op_exc),
      .op_denorm    (op_denorm),
      .round_mode   (round_mode),
      .flush_denorm (flush_denorm),
      .trap_req     (trap_req)
   );

   typedef struct packed {
      logic        wr;
      logic [31:0] wd;
      logic        op;
      logic [5:0]  exc;
      logic        dn;
      logic [31:0] exp;
      logic        trap;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'hFFFF_FFFF, 1'b0, 6'h00, 1'b0, 32'h0000_7D03, 1'b0, 4'd2},  // R2 R3
      '{1'b1, 32'h0000_0002, 1'b0, 6'h00, 1'b0, 32'h0000_0002, 1'b0, 4'd2},  // R2
      '{1'b0, 32'h0000_0000, 1'b1, 6'h03, 1'b0, 32'h0003_000E, 1'b0, 4'd8},  // R8
      '{1'b0, 32'h0000_0000, 1'b1, 6'h00, 1'b0, 32'h0003_0002, 1'b0, 4'd5},  // R5
      '{1'b1, 32'h0002_0000, 1'b0, 6'h00, 1'b0, 32'h0002_0000, 1'b0, 4'd4},  // R4
      '{1'b1, 32'h0002_1000, 1'b0, 6'h00, 1'b0, 32'h0002_1000, 1'b0, 4'd2},  // R2
      '{1'b0, 32'h0000_0000, 1'b1, 6'h04, 1'b0, 32'h0002_1010, 1'b1, 4'd7},  // R7
      '{1'b0, 32'h0000_0000, 1'b1, 6'h0C, 1'b0, 32'h0002_1030, 1'b1, 4'd9},  // R9
      '{1'b0, 32'h0000_0000, 1'b0, 6'h00, 1'b0, 32'h0002_1030, 1'b0, 4'd7},  // R7
      '{1'b0, 32'h0000_0000, 1'b1, 6'h00, 1'b1, 32'h0002_1080, 1'b1, 4'd6},  // R6
      '{1'b1, 32'h0002_1100, 1'b0, 6'h00, 1'b0, 32'h0002_1100, 1'b0, 4'd4},  // R4
      '{1'b0, 32'h0000_0000, 1'b1, 6'h08, 1'b1, 32'h000A_1120, 1'b0, 4'd6},  // R6 R8
      '{1'b1, 32'h0000_0000, 1'b1, 6'h10, 1'b0, 32'h0010_0040, 1'b0, 4'd10}, // R10
      '{1'b1, 32'hFFFF_FFFF, 1'b0, 6'h00, 1'b0, 32'h0010_7D43, 1'b0, 4'd4},  // R4
      '{1'b1, 32'h0000_0200, 1'b0, 6'h00, 1'b0, 32'h0000_0000, 1'b0, 4'd3}   // R3
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic check_all(input int req, input logic [31:0] exp, input logic exp_trap);
      string tag;
      tag = $sformatf("R%0d", req);
      check({tag, " rd_data"}, csr_rd_data, exp);
      check({tag, " trap_req"}, {31'b0, trap_req}, {31'b0, exp_trap});
      check({tag, " round_mode"}, {30'b0, round_mode}, {30'b0, exp[1:0]});
      check({tag, " flush_denorm"}, {31'b0, flush_denorm}, {31'b0, exp[8]});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all(1, 32'h0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         csr_wr_en   = VECS[i].wr;
         csr_wr_data = VECS[i].wd;
         op_valid    = VECS[i].op;
         op_exc      = VECS[i].exc;
         op_denorm   = VECS[i].dn;
         @(negedge clk);
         check_all(int'(VECS[i].req), VECS[i].exp, VECS[i].trap);
      end
      csr_wr_en = 1'b0;
      op_valid  = 1'b0;
      op_denorm = 1'b0;

      // R7: enabled overflow traps, then drops after one cycle
      csr_wr_en = 1'b1; csr_wr_data = 32'h0000_0801;
      @(negedge clk);
      csr_wr_en = 1'b0;
      op_valid = 1'b1; op_exc = 6'h02;
      @(negedge clk);
      op_valid = 1'b0; op_exc = 6'h00;
      check_all(7, 32'h0000_0809, 1'b1);
      @(negedge clk);
      check_all(7, 32'h0000_0809, 1'b0);

      // R1: reset from a busy state clears everything
      csr_wr_en = 1'b1; csr_wr_data = 32'hFFFF_FFFF;
      op_valid = 1'b1; op_exc = 6'h3F;
      @(negedge clk);
      csr_wr_en = 1'b0; op_valid = 1'b0; op_exc = 6'h00;
      rst_n = 1'b0;
      @(negedge clk);
      check_all(1, 32'h0, 1'b0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule